// File: doc/BRIEF.md
# Background Integrator Leakage Calibration Loop

This block trims a leakage-compensation control word while the converter keeps running, so that a lossy switched-capacitor integrator behaves like an ideal one. It drives a periodic, 50%-duty probe square wave into the analog path and watches the quantizer output for the settled part of the step response that the probe excites. Each sample is weighted by a three-valued mask. The mask is zero while the step response is still moving and carries the probe's sign once it has settled. The weighted samples are summed, and whenever the sum reaches a symmetric threshold a single up or down decision is issued and the sum is cleared. Each decision moves the control word by one step.

The sign of the mask relative to the probe is a parameter. The same block therefore serves a stage whose settled response is in phase with the probe and a stage whose response is inverted. The width of the control word is also a parameter: the first stage uses six bits, the second five. The threshold is an input that software sets. It trades settling speed against residual wander of the trimmed value. An enable freezes the whole loop in place.

Top module: `leak_cal_loop`

## Requirements
- R1: On reset the control word is mid-scale (32 for six bits, 16 for five bits), both decision outputs are low, the correlation sum is zero and the probe phase restarts at the start of its positive half.
- R2: While enabled, the probe is positive (inj_p=1, inj_n=0) for 32 cycles, then negative (inj_p=0, inj_n=1) for 32 cycles, and repeats with a 64-cycle period. At most one of the two is ever high.
- R3: In the first 16 cycles of each probe half the mask is 0, so samples taken there leave the correlation sum unchanged.
- R4: In the last 16 cycles of each half the mask is +1 during the positive half and −1 during the negative half. With MASK_INV=1 these signs are swapped.
- R5: Each enabled cycle adds sample×mask to the sum. The sample is signed two's complement: 3 bits, with levels −3, −1, +1 and +3. If the new sum is ≥ thr, dec_up pulses for one cycle. If it is ≤ −thr, dec_dn pulses for one cycle. In either case the sum restarts at 0. The two pulses are never high together.
- R6: The control word rises by one on the edge that raises dec_up and falls by one on the edge that raises dec_dn. Without a decision it does not change.
- R7: The control word saturates: it stays at its all-ones maximum on an up decision and at 0 on a down decision, and never wraps.
- R8: With en low, the probe outputs are both 0, no decision is issued, and the phase, the sum and the control word hold. On re-enable the loop continues from where it stopped.
- R9: The threshold is taken from the thr input every cycle, so a new value applies from the next sample. Values must be at least 1.
- R10: A five-bit, mask-inverted instance obeys R1 to R9 with its own range of 0 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Loop enable |
| thr | input | THR_W | Decision threshold, unsigned, ≥ 1 |
| samp | input | SAMP_W | Signed quantizer sample |
| inj_p | output | 1 | Probe drive, positive level |
| inj_n | output | 1 | Probe drive, negative level |
| dec_up | output | 1 | One-cycle up decision |
| dec_dn | output | 1 | One-cycle down decision |
| ctrl | output | CTRL_W | Saturating compensation control word |

## Verification
A threshold crossing can land in the same cycle as the end of a probe half, and a decision can land in the same cycle that the control word sits at one of its rails. Both cases are provoked on purpose. A threshold of 48 under constant full-scale input makes the crossing fall exactly on the last live cycle of each half. A threshold of 1 under input correlated with the probe drives both instances into and along their rails. A cycle-exact model in the bench, built from the requirements, judges the pulses, the control word and the probe phase at every cycle, for the plain instance and the inverted one side by side.

// File: rtl/leak_cal_loop.sv
module leak_cal_loop #(
  parameter int CTRL_W   = 6,
  parameter int HALF     = 32,
  parameter int BLANK    = 16,
  parameter int THR_W    = 10,
  parameter int SAMP_W   = 3,
  parameter bit MASK_INV = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [THR_W-1:0]  thr,
  input  logic [SAMP_W-1:0] samp,
  output logic              inj_p,
  output logic              inj_n,
  output logic              dec_up,
  output logic              dec_dn,
  output logic [CTRL_W-1:0] ctrl
);
  localparam int PER_W = $clog2(2*HALF);
  localparam int ACC_W = THR_W + SAMP_W + 1;
  localparam logic [PER_W-1:0]  HALF_C  = PER_W'(HALF);
  localparam logic [PER_W-1:0]  LAST_C  = PER_W'(2*HALF-1);
  localparam logic [PER_W-1:0]  BLANK_C = PER_W'(BLANK);
  localparam logic [CTRL_W-1:0] CMAX    = {CTRL_W{1'b1}};
  localparam logic [CTRL_W-1:0] CMID    = CTRL_W'(1) << (CTRL_W-1);

  logic [PER_W-1:0]        cnt;
  logic signed [ACC_W-1:0] acc;

  logic                    first_half, live, mask_pos, hit_hi, hit_lo;
  logic [PER_W-1:0]        pos;
  logic signed [ACC_W-1:0] samp_s, thr_s, prod, acc_sum;

  assign first_half = cnt < HALF_C;
  assign pos        = first_half ? cnt : cnt - HALF_C;
  assign live       = pos >= BLANK_C;
  assign mask_pos   = first_half ^ MASK_INV;
  assign samp_s     = {{(ACC_W-SAMP_W){samp[SAMP_W-1]}}, samp};
  assign thr_s      = {{(ACC_W-THR_W){1'b0}}, thr};
  assign prod       = !live ? '0 : (mask_pos ? samp_s : -samp_s);
  assign acc_sum    = acc + prod;
  assign hit_hi     = acc_sum >= thr_s;
  assign hit_lo     = acc_sum <= -thr_s;

  assign inj_p = en &&  first_half;
  assign inj_n = en && !first_half;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      acc    <= '0;
      dec_up <= 1'b0;
      dec_dn <= 1'b0;
      ctrl   <= CMID;
    end else if (en) begin
      cnt    <= (cnt == LAST_C) ? '0 : cnt + 1'b1;
      acc    <= (hit_hi || hit_lo) ? '0 : acc_sum;
      dec_up <= hit_hi;
      dec_dn <= hit_lo && !hit_hi;
      if (hit_hi && ctrl != CMAX)
        ctrl <= ctrl + 1'b1;
      else if (hit_lo && !hit_hi && ctrl != '0)
        ctrl <= ctrl - 1'b1;
    end else begin
      dec_up <= 1'b0;
      dec_dn <= 1'b0;
    end
  end

  // R2
  inj_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inj_p, inj_n}));

  // R5
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_up && dec_dn));

  // R6
  ctrl_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_up) && $past(ctrl) != CMAX |-> ctrl == $past(ctrl) + 1'b1);

  // R6
  ctrl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_up && !dec_dn |-> $stable(ctrl));

  // R7
  ctrl_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_dn && $past(ctrl) == '0 |-> ctrl == '0);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(ctrl) && !dec_up && !dec_dn);

  // R3
  blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && !live && $stable(thr) && thr != '0 |=> !dec_up && !dec_dn);
endmodule

// File: tb/leak_cal_loop_tb.sv
module leak_cal_loop_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [9:0] thr = 10'd48;
  logic [2:0] samp = '0;
  logic       p0, n0, u0, d0, p1, n1, u1, d1;
  logic [5:0] c0;
  logic [4:0] c1;

  int total = 0, bad = 0;
  bit done = 0;

  int m_cnt[2], m_acc[2], m_ctrl[2], m_up[2], m_dn[2];
  int cmax[2] = '{63, 31};
  int cinv[2] = '{0, 1};

  always #2.5 clk = ~clk;

  leak_cal_loop #(.CTRL_W(6), .MASK_INV(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .thr(thr), .samp(samp),
    .inj_p(p0), .inj_n(n0), .dec_up(u0), .dec_dn(d0), .ctrl(c0));

  leak_cal_loop #(.CTRL_W(5), .MASK_INV(1'b1)) u_dut2 (
    .clk(clk), .rst_n(rst_n), .en(en), .thr(thr), .samp(samp),
    .inj_p(p1), .inj_n(n1), .dec_up(u1), .dec_dn(d1), .ctrl(c1));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      m_cnt[k] = 0; m_acc[k] = 0; m_up[k] = 0; m_dn[k] = 0;
      m_ctrl[k] = (cmax[k] + 1) / 2;
    end
  endtask

  task automatic compare(input string req);
    int ep;
    ep = (en && m_cnt[0] < 32) ? 1 : 0;
    chk(int'(c0) == m_ctrl[0], req, "ctrl6", int'(c0), m_ctrl[0]);
    chk(int'(u0) == m_up[0] && int'(d0) == m_dn[0], req, "dec6 up*2+dn",
        int'(u0)*2 + int'(d0), m_up[0]*2 + m_dn[0]);
    chk(int'(c1) == m_ctrl[1], {req, " R10"}, "ctrl5", int'(c1), m_ctrl[1]);
    chk(int'(u1) == m_up[1] && int'(d1) == m_dn[1], {req, " R10"}, "dec5 up*2+dn",
        int'(u1)*2 + int'(d1), m_up[1]*2 + m_dn[1]);
    chk(int'(p0) == ep && int'(n0) == (en ? 1 - ep : 0), {req, " R2"},
        "inj p*2+n", int'(p0)*2 + int'(n0), ep*2 + (en ? 1 - ep : 0));
    chk(p1 == p0 && n1 == n0, {req, " R2"}, "inj match", int'(p1), int'(p0));
  endtask

  // one clock: drive sample at negedge, advance model, compare at next negedge
  task automatic tick(input int s, input string req);
    samp = 3'(s);
    for (int k = 0; k < 2; k++) begin
      if (en) begin
        int first, pos, mk, sum;
        first = (m_cnt[k] < 32) ? 1 : 0;
        pos = first ? m_cnt[k] : m_cnt[k] - 32;
        mk = (pos >= 16) ? (((first ^ cinv[k]) != 0) ? 1 : -1) : 0;
        sum = m_acc[k] + s * mk;
        m_up[k] = (sum >= int'(thr)) ? 1 : 0;
        m_dn[k] = (!m_up[k] && sum <= -int'(thr)) ? 1 : 0;
        m_acc[k] = (m_up[k] || m_dn[k]) ? 0 : sum;
        if (m_up[k] && m_ctrl[k] < cmax[k]) m_ctrl[k]++;
        if (m_dn[k] && m_ctrl[k] > 0) m_ctrl[k]--;
        m_cnt[k] = (m_cnt[k] + 1) % 64;
      end else begin
        m_up[k] = 0; m_dn[k] = 0;
      end
    end
    @(negedge clk);
    compare(req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; en = 1'b0; samp = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic t_reset();
    do_reset();
    chk(c0 == 6'd32, "R1", "ctrl6 mid", int'(c0), 32);
    chk(c1 == 5'd16, "R1", "ctrl5 mid", int'(c1), 16);
    chk(!u0 && !d0 && !u1 && !d1, "R1", "no decision", int'(u0|d0|u1|d1), 0);
    en = 1'b1;
    @(posedge clk); #1;
    en = 1'b0;
    @(negedge clk);
    m_cnt[0] = 1; m_cnt[1] = 1;
    compare("R1");
    do_reset();
  endtask

  task automatic t_cross_at_boundary();
    int ups;
    do_reset();
    thr = 10'd48; en = 1'b1;
    ups = 0;
    for (int i = 0; i < 64; i++) begin
      tick(3, "R5");
      if (i == 31) chk(u0 == 1'b1, "R5", "pulse at last live cycle", int'(u0), 1);
      if (u0) ups++;
    end
    chk(ups == 1, "R5", "one up per period", ups, 1);
    chk(c0 == 6'd32, "R6", "ctrl back at mid", int'(c0), 32);
  endtask

  task automatic t_blank_only();
    do_reset();
    thr = 10'd1; en = 1'b1;
    for (int i = 0; i < 192; i++)
      tick(((i % 32) < 16) ? 3 : 0, "R3");
    chk(c0 == 6'd32 && c1 == 5'd16, "R3", "blank samples ignored", int'(c0), 32);
  endtask

  task automatic t_correlated();
    do_reset();
    thr = 10'd8; en = 1'b1;
    for (int i = 0; i < 128; i++)
      tick(((i % 64) < 32) ? 3 : -3, "R4");
    chk(c0 > 6'd32, "R4", "plain instance rises", int'(c0), 33);
    chk(c1 < 5'd16, "R4", "inverted instance falls", int'(c1), 15);
  endtask

  task automatic t_saturate();
    do_reset();
    thr = 10'd1; en = 1'b1;
    for (int i = 0; i < 256; i++)
      tick(((i % 64) < 32) ? 1 : -1, "R7");
    chk(c0 == 6'd63, "R7", "ctrl6 top rail", int'(c0), 63);
    chk(c1 == 5'd0, "R7", "ctrl5 bottom rail", int'(c1), 0);
    for (int i = 0; i < 256; i++)
      tick(((i % 64) < 32) ? -3 : 3, "R7");
    chk(c0 == 6'd0, "R7", "ctrl6 bottom rail", int'(c0), 0);
    chk(c1 == 5'd31, "R7", "ctrl5 top rail", int'(c1), 31);
  endtask

  task automatic t_hold();
    int keep;
    do_reset();
    thr = 10'd2; en = 1'b1;
    for (int i = 0; i < 40; i++) tick(3, "R8");
    keep = int'(c0);
    en = 1'b0;
    for (int i = 0; i < 50; i++) tick(3, "R8");
    chk(int'(c0) == keep, "R8", "ctrl held", int'(c0), keep);
    chk(!p0 && !n0, "R8", "probe off", int'(p0|n0), 0);
    en = 1'b1;
    for (int i = 0; i < 60; i++) tick(((i % 3) == 0) ? -1 : 3, "R8");
  endtask

  task automatic t_threshold();
    do_reset();
    en = 1'b1;
    thr = 10'd20;
    for (int i = 0; i < 100; i++) tick(1, "R9");
    thr = 10'd3;
    for (int i = 0; i < 100; i++) tick(1, "R9");
    thr = 10'd500;
    for (int i = 0; i < 100; i++) tick(-3, "R9");
  endtask

  task automatic t_mixed();
    int lv[4] = '{-3, -1, 1, 3};
    do_reset();
    en = 1'b1; thr = 10'd6;
    for (int i = 0; i < 1500; i++) begin
      if ((i % 211) == 0) en = 1'b0;
      if ((i % 211) == 9) en = 1'b1;
      tick(lv[$urandom_range(3, 0)], "R5 R6");
    end
  endtask

  initial begin
    t_reset();
    t_cross_at_boundary();
    t_blank_only();
    t_correlated();
    t_saturate();
    t_hold();
    t_threshold();
    t_mixed();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule